// File: doc/BRIEF.md
# Paged MDIO-to-32-bit Register Bridge

This block sits on a clause-22 MDIO management bus as a slave. It gives a station manager access to a wide internal register space of 32-bit words. Each word is exposed as two adjacent 16-bit MDIO registers. A small page register supplies the upper word-address bits. The slave's own PHY-address bits and the MDIO register number supply the rest. The bridge decodes the frames that are addressed to it and keeps the page and a held upper half. It turns each completed access into a single request on a simple parallel register bus that uses a request/acknowledge handshake.

Software changes the page by writing one fixed MDIO location. It writes a word by sending the upper half (odd register) and then the lower half (even register). The write is committed only when the lower half arrives. It reads a word by reading the lower half first. That read fetches the whole word, and a following read of the upper half returns the upper bits of that same fetch, so the two halves always belong together. MDC and MDIO are oversampled in the system clock domain. The bridge changes its output only after a rising MDC edge.

Top module: `mdio_page_bridge`

## Requirements
- R1: A write frame to PHY address 0x1f, register 0x10 loads the low PAGE_W bits of its data into the page. A read of the same location returns the page zero-extended to 16 bits. The page is 0 after reset.
- R2: A write frame to an odd register at a data PHY address (0x10 to 0x17) makes no bus request. It only replaces the held upper half.
- R3: A write frame to an even register at a data PHY address makes exactly one bus request with rb_we=1. Its rb_wdata carries the held upper half in bits 31:16 and the frame's data in bits 15:0.
- R4: The bus word address is the concatenation {page, PHY address bits 2:0, register bits 4:1}.
- R5: A read frame to an even register at a data PHY address makes exactly one bus request with rb_we=0. It returns bits 15:0 of the fetched word and keeps all 32 bits.
- R6: A read frame to an odd register at a data PHY address makes no bus request. It returns bits 31:16 of the word kept by the most recent lower-half read, which is 0 if there has been none.
- R7: A frame to any other PHY address, or to PHY 0x1f with a register other than 0x10, makes no bus request and leaves the page unchanged. mdio_oe stays 0 throughout.
- R8: A frame whose opcode is neither 10 (read) nor 01 (write), or whose start pattern is not 0 then 1, is ignored just as in R7. A frame is recognised only after at least PRE_MIN preamble ones.
- R9: For a read frame addressed to the bridge, mdio_oe rises after the first turnaround bit and drives 0 in the second turnaround bit. It then drives the 16 data bits MSB first and falls after the last data bit. mdio_oe is 0 out of reset and no write request is pending while it is high.
- R10: rb_req is 0 after reset. Once raised, it stays high with rb_we, rb_addr and rb_wdata unchanged until the clock edge at which rb_ack is sampled high.
- R11: The held upper half persists, so that several even-register writes without an intervening odd write all reuse the same upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than MDC |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Management data as seen on the wire |
| mdio_o | output | 1 | Management data driven by the bridge |
| mdio_oe | output | 1 | High while the bridge drives the data line |
| rb_req | output | 1 | Register bus request, held until acknowledged |
| rb_we | output | 1 | 1 for a write request, 0 for a read |
| rb_addr | output | PAGE_W+7 | Internal word address |
| rb_wdata | output | 32 | Write data |
| rb_rdata | input | 32 | Read data, valid with rb_ack |
| rb_ack | input | 1 | Request completion |

## Verification
Two things can land in the same system-clock cycle. One is the register-bus acknowledge that completes a lower-half fetch. The other is the frame walker processing an MDC edge in the turnaround. The bench's memory model answers after a random latency of 0 to 3 cycles, so the acknowledge moves across the cycles around those edges. The bench then judges the read by the 16 bits the manager samples, against a data pattern computed from the expected address. Random mixes of page changes, half writes, half reads and frames to foreign addresses are checked against a bench model of the page, the held upper half and the last fetched word.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

   localparam int HALF_W   = 16;
   localparam int WORD_W   = 32;
   localparam int FIELD_W  = 5;
   localparam int HDR_BITS = 13;

   // fixed management-address layout
   localparam logic [4:0] PG_PHY    = 5'h1f;
   localparam logic [4:0] PG_REG    = 5'h10;
   localparam logic [4:0] DATA_SEL  = 5'h10;
   localparam logic [4:0] DATA_MASK = 5'h17;

   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;

   typedef enum logic [1:0] {
      F_PRE,
      F_HDR,
      F_TA,
      F_DATA
   } fstate_t;

   function automatic logic is_data(input logic [4:0] p);
      return ((p & ~DATA_MASK) == 5'h00) && ((p & DATA_SEL) == DATA_SEL);
   endfunction

   function automatic logic claims(input logic [4:0] p, input logic [4:0] r);
      return is_data(p) || ((p == PG_PHY) && (r == PG_REG));
   endfunction

endpackage

// File: rtl/mpb_sync.sv
module mpb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc,
   input  logic mdio_i,
   output logic rise,
   output logic din
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mpb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] mdc_sh;
   logic [STAGES-1:0] dio_sh;
   logic              mdc_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mdc_sh   <= '0;
         dio_sh   <= '1;
         mdc_last <= 1'b0;
      end else begin
         mdc_sh   <= {mdc_sh[STAGES-2:0], mdc};
         dio_sh   <= {dio_sh[STAGES-2:0], mdio_i};
         mdc_last <= mdc_sh[STAGES-1];
      end
   end

   assign rise = mdc_sh[STAGES-1] & ~mdc_last;
   assign din  = dio_sh[STAGES-1];

endmodule

// File: rtl/mpb_frame.sv
module mpb_frame
   import mpb_pkg::*;
#(
   parameter int PRE_MIN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              din,
   input  logic [HALF_W-1:0] rd_half,
   output logic              hdr_stb,
   output logic              hdr_rd,
   output logic [4:0]        hdr_phy,
   output logic [4:0]        hdr_reg,
   output logic              wr_stb,
   output logic [HALF_W-1:0] wr_data,
   output logic              mdio_o,
   output logic              mdio_oe
);

   localparam int CW = $clog2(PRE_MIN + 1);

   generate
      if (PRE_MIN < 1 || PRE_MIN > 32) begin : g_bad_pre
         $error("mpb_frame: PRE_MIN must lie in 1..32");
      end
   endgenerate

   fstate_t             st;
   logic [CW-1:0]       ones;
   logic [3:0]          cnt;
   logic [11:0]         hdr_q;
   logic [HDR_BITS-1:0] hdr_nxt;
   logic                mine_q, rd_q, wr_q;
   logic [HALF_W-1:0]   sh;
   logic                n_ok, n_rd, n_wr, n_mine;

   always_comb begin
      hdr_nxt = {hdr_q, din};
      n_rd    = (hdr_nxt[11:10] == OP_RD);
      n_wr    = (hdr_nxt[11:10] == OP_WR);
      n_ok    = hdr_nxt[12] && (n_rd || n_wr);
      n_mine  = n_ok && claims(hdr_nxt[9:5], hdr_nxt[4:0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= F_PRE;
         ones    <= '0;
         cnt     <= '0;
         hdr_q   <= '0;
         mine_q  <= 1'b0;
         rd_q    <= 1'b0;
         wr_q    <= 1'b0;
         sh      <= '0;
         hdr_stb <= 1'b0;
         hdr_rd  <= 1'b0;
         hdr_phy <= '0;
         hdr_reg <= '0;
         wr_stb  <= 1'b0;
         mdio_o  <= 1'b1;
         mdio_oe <= 1'b0;
      end else begin
         hdr_stb <= 1'b0;
         wr_stb  <= 1'b0;
         if (rise) begin
            unique case (st)
               F_PRE: begin
                  if (din) begin
                     if (ones != CW'(PRE_MIN)) ones <= ones + CW'(1);
                  end else begin
                     if (ones == CW'(PRE_MIN)) begin
                        st  <= F_HDR;
                        cnt <= '0;
                     end
                     ones <= '0;
                  end
               end
               F_HDR: begin
                  hdr_q <= hdr_nxt[11:0];
                  cnt   <= cnt + 4'd1;
                  if (cnt == 4'(HDR_BITS - 1)) begin
                     mine_q  <= n_mine;
                     rd_q    <= n_rd;
                     wr_q    <= n_wr;
                     hdr_stb <= n_mine;
                     hdr_rd  <= n_rd;
                     hdr_phy <= hdr_nxt[9:5];
                     hdr_reg <= hdr_nxt[4:0];
                     st      <= F_TA;
                     cnt     <= '0;
                  end
               end
               F_TA: begin
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'd0) begin
                     if (mine_q && rd_q) begin
                        mdio_oe <= 1'b1;
                        mdio_o  <= 1'b0;
                     end
                  end else begin
                     sh <= rd_half;
                     if (mine_q && rd_q) mdio_o <= rd_half[HALF_W-1];
                     st  <= F_DATA;
                     cnt <= '0;
                  end
               end
               F_DATA: begin
                  sh     <= {sh[HALF_W-2:0], din};
                  mdio_o <= sh[HALF_W-2];
                  cnt    <= cnt + 4'd1;
                  if (cnt == 4'(HALF_W - 1)) begin
                     mdio_oe <= 1'b0;
                     mdio_o  <= 1'b1;
                     st      <= F_PRE;
                     ones    <= '0;
                     if (mine_q && wr_q) wr_stb <= 1'b1;
                  end
               end
               default: st <= F_PRE;
            endcase
         end
      end
   end

   assign wr_data = sh;

endmodule

// File: rtl/mpb_xlate.sv
module mpb_xlate
   import mpb_pkg::*;
#(
   parameter int PAGE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_stb,
   input  logic              hdr_rd,
   input  logic [4:0]        hdr_phy,
   input  logic [4:0]        hdr_reg,
   input  logic              wr_stb,
   input  logic [HALF_W-1:0] wr_data,
   output logic [HALF_W-1:0] rd_half,
   output logic [PAGE_W-1:0] page_o,
   output logic              rb_req,
   output logic              rb_we,
   output logic [PAGE_W+6:0] rb_addr,
   output logic [WORD_W-1:0] rb_wdata,
   input  logic [WORD_W-1:0] rb_rdata,
   input  logic              rb_ack
);

   logic [PAGE_W-1:0] page_q;
   logic [HALF_W-1:0] hi_q;
   logic [WORD_W-1:0] word_q;
   logic [4:0]        tgt_phy;
   logic [4:0]        tgt_reg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q   <= '0;
         hi_q     <= '0;
         word_q   <= '0;
         tgt_phy  <= '0;
         tgt_reg  <= '0;
         rb_req   <= 1'b0;
         rb_we    <= 1'b0;
         rb_addr  <= '0;
         rb_wdata <= '0;
      end else begin
         if (rb_req && rb_ack) begin
            rb_req <= 1'b0;
            if (!rb_we) word_q <= rb_rdata;
         end
         if (hdr_stb) begin
            tgt_phy <= hdr_phy;
            tgt_reg <= hdr_reg;
            if (hdr_rd && is_data(hdr_phy) && !hdr_reg[0]) begin
               rb_req  <= 1'b1;
               rb_we   <= 1'b0;
               rb_addr <= {page_q, hdr_phy[2:0], hdr_reg[4:1]};
            end
         end
         if (wr_stb) begin
            if (!is_data(tgt_phy)) begin
               page_q <= wr_data[PAGE_W-1:0];
            end else if (tgt_reg[0]) begin
               hi_q <= wr_data;
            end else begin
               rb_req   <= 1'b1;
               rb_we    <= 1'b1;
               rb_addr  <= {page_q, tgt_phy[2:0], tgt_reg[4:1]};
               rb_wdata <= {hi_q, wr_data};
            end
         end
      end
   end

   always_comb begin
      if (!is_data(tgt_phy))  rd_half = HALF_W'(page_q);
      else if (tgt_reg[0])    rd_half = word_q[WORD_W-1:HALF_W];
      else                    rd_half = word_q[HALF_W-1:0];
   end

   assign page_o = page_q;

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
   import mpb_pkg::*;
#(
   parameter int PAGE_W      = 9,
   parameter int PRE_MIN     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdc,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              rb_req,
   output logic              rb_we,
   output logic [PAGE_W+6:0] rb_addr,
   output logic [31:0]       rb_wdata,
   input  logic [31:0]       rb_rdata,
   input  logic              rb_ack
);

   generate
      if (PAGE_W < 1 || PAGE_W > 9) begin : g_bad_page
         $error("mdio_page_bridge: PAGE_W must lie in 1..9");
      end
   endgenerate

   logic              rise_w, din_w;
   logic              hdr_stb_w, hdr_rd_w;
   logic [4:0]        hdr_phy_w, hdr_reg_w;
   logic              wr_stb_w;
   logic [HALF_W-1:0] wr_data_w, rd_half_w;
   logic [PAGE_W-1:0] page_w;

   mpb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
      .rise(rise_w), .din(din_w)
   );

   mpb_frame #(.PRE_MIN(PRE_MIN)) u_frm (
      .clk(clk), .rst_n(rst_n), .rise(rise_w), .din(din_w),
      .rd_half(rd_half_w),
      .hdr_stb(hdr_stb_w), .hdr_rd(hdr_rd_w),
      .hdr_phy(hdr_phy_w), .hdr_reg(hdr_reg_w),
      .wr_stb(wr_stb_w), .wr_data(wr_data_w),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   mpb_xlate #(.PAGE_W(PAGE_W)) u_xl (
      .clk(clk), .rst_n(rst_n),
      .hdr_stb(hdr_stb_w), .hdr_rd(hdr_rd_w),
      .hdr_phy(hdr_phy_w), .hdr_reg(hdr_reg_w),
      .wr_stb(wr_stb_w), .wr_data(wr_data_w),
      .rd_half(rd_half_w), .page_o(page_w),
      .rb_req(rb_req), .rb_we(rb_we), .rb_addr(rb_addr),
      .rb_wdata(rb_wdata), .rb_rdata(rb_rdata), .rb_ack(rb_ack)
   );

endmodule

// File: rtl/mpb_chk.sv
module mpb_chk #(
   parameter int PAGE_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mdio_oe,
   input logic              rb_req,
   input logic              rb_we,
   input logic [PAGE_W+6:0] rb_addr,
   input logic [31:0]       rb_wdata,
   input logic              rb_ack,
   input logic [PAGE_W-1:0] page,
   input logic              wr_stb
);

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_req && !rb_ack) |=> rb_req);

   // R10
   req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_req && !rb_ack) |=> ($stable(rb_addr) && $stable(rb_we) && $stable(rb_wdata)));

   // R9
   oe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> !(rb_req && rb_we));

   // R1
   page_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(page) |-> $past(wr_stb));

endmodule

bind mdio_page_bridge mpb_chk #(.PAGE_W(PAGE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mdio_oe(mdio_oe),
   .rb_req(rb_req), .rb_we(rb_we), .rb_addr(rb_addr),
   .rb_wdata(rb_wdata), .rb_ack(rb_ack),
   .page(page_w), .wr_stb(wr_stb_w)
);

// File: tb/mdio_page_bridge_tb_top.sv
module mdio_page_bridge_tb_top;

   localparam int PAGE_W = 9;
   localparam int AW     = PAGE_W + 7;
   localparam int HALF   = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          mdc   = 1'b0;
   logic          m_oe  = 1'b0;
   logic          m_drv = 1'b1;
   logic          mdio_o, mdio_oe;
   logic          rb_req, rb_we;
   logic [AW-1:0] rb_addr;
   logic [31:0]   rb_wdata;
   logic [31:0]   rb_rdata = '0;
   logic          rb_ack   = 1'b0;

   wire mline = mdio_oe ? mdio_o : (m_oe ? m_drv : 1'b1);

   mdio_page_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mline),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .rb_req(rb_req), .rb_we(rb_we), .rb_addr(rb_addr),
      .rb_wdata(rb_wdata), .rb_rdata(rb_rdata), .rb_ack(rb_ack)
   );

   int total = 0;
   int bad   = 0;

   function automatic logic [31:0] pat(input logic [AW-1:0] a);
      return {a ^ 16'hC3A5, a + 16'h1357};
   endfunction

   function automatic logic [AW-1:0] exp_addr(input logic [PAGE_W-1:0] pg,
                                              input logic [4:0] p, input logic [4:0] r);
      return {pg, p[2:0], r[4:1]};
   endfunction

   // register-bus memory model with random latency
   int            lat = 0;
   int            req_cnt = 0;
   logic [AW-1:0] last_addr = '0;
   logic          last_we = 1'b0;
   logic [31:0]   last_wdata = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         rb_ack = 1'b0;
         lat    = 0;
      end else if (rb_ack) begin
         rb_ack = 1'b0;
      end else if (rb_req) begin
         if (lat == 0) begin
            rb_ack     = 1'b1;
            rb_rdata   = pat(rb_addr);
            req_cnt++;
            last_addr  = rb_addr;
            last_we    = rb_we;
            last_wdata = rb_wdata;
            lat        = $urandom_range(0, 3);
         end else begin
            lat--;
         end
      end
   end

   logic oe_seen = 1'b0;
   always @(posedge clk) if (mdio_oe) oe_seen = 1'b1;

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      m_oe  = 1'b1;
      m_drv = b;
      repeat (HALF) @(negedge clk);
      mdc = 1'b1;
      repeat (HALF) @(negedge clk);
      mdc = 1'b0;
   endtask

   task automatic samp_bit(output logic b);
      m_oe = 1'b0;
      repeat (HALF) @(negedge clk);
      b   = mline;
      mdc = 1'b1;
      repeat (HALF) @(negedge clk);
      mdc = 1'b0;
   endtask

   task automatic frame(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] wd, input logic st1,
                        output logic [15:0] rd, output logic ta2);
      logic b;
      oe_seen = 1'b0;
      rd  = '0;
      ta2 = 1'b1;
      for (int i = 0; i < 32; i++) send_bit(1'b1);
      send_bit(1'b0);
      send_bit(st1);
      for (int i = 1; i >= 0; i--) send_bit(op[i]);
      for (int i = 4; i >= 0; i--) send_bit(p[i]);
      for (int i = 4; i >= 0; i--) send_bit(r[i]);
      if (op == 2'b10) begin
         samp_bit(b);
         samp_bit(ta2);
         for (int i = 15; i >= 0; i--) begin
            samp_bit(b);
            rd[i] = b;
         end
      end else begin
         send_bit(1'b1);
         send_bit(1'b0);
         for (int i = 15; i >= 0; i--) send_bit(wd[i]);
      end
      send_bit(1'b1);
      send_bit(1'b1);
      m_oe = 1'b0;
   endtask

   // bench model
   logic [PAGE_W-1:0] page_m = '0;
   logic [15:0]       hi_m   = '0;
   logic [31:0]       word_m = '0;

   task automatic do_page_wr(input logic [15:0] d);
      logic [15:0] rd; logic t;
      int c0 = req_cnt;
      frame(2'b01, 5'h1f, 5'h10, d, 1'b1, rd, t);
      page_m = d[PAGE_W-1:0];
      chk("R1", "page write makes no request", req_cnt, c0);
   endtask

   task automatic do_page_rd();
      logic [15:0] rd; logic t;
      frame(2'b10, 5'h1f, 5'h10, 16'h0, 1'b1, rd, t);
      chk("R1", "page readback", {16'h0, rd}, {16'h0, 16'(page_m)});
      chk("R9", "turnaround zero on page read", {31'h0, t}, 32'h0);
   endtask

   task automatic do_hi_wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
      logic [15:0] rd; logic t;
      int c0 = req_cnt;
      frame(2'b01, p, r | 5'h01, d, 1'b1, rd, t);
      hi_m = d;
      chk("R2", "odd write makes no request", req_cnt, c0);
      chk("R9", "no drive on write frame", {31'h0, oe_seen}, 32'h0);
   endtask

   task automatic do_lo_wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
      logic [15:0] rd; logic t;
      int c0 = req_cnt;
      logic [4:0] re = r & 5'h1e;
      frame(2'b01, p, re, d, 1'b1, rd, t);
      chk("R3", "even write request count", req_cnt, c0 + 1);
      chk("R3", "even write direction", {31'h0, last_we}, 32'h1);
      chk("R3", "write data halves (R11 held upper)", last_wdata, {hi_m, d});
      chk("R4", "write address", {16'h0, 16'(last_addr)}, {16'h0, 16'(exp_addr(page_m, p, re))});
   endtask

   task automatic do_lo_rd(input logic [4:0] p, input logic [4:0] r);
      logic [15:0] rd; logic t;
      int c0 = req_cnt;
      logic [4:0] re = r & 5'h1e;
      frame(2'b10, p, re, 16'h0, 1'b1, rd, t);
      word_m = pat(exp_addr(page_m, p, re));
      chk("R5", "even read request count", req_cnt, c0 + 1);
      chk("R5", "even read direction", {31'h0, last_we}, 32'h0);
      chk("R4", "read address", {16'h0, 16'(last_addr)}, {16'h0, 16'(exp_addr(page_m, p, re))});
      chk("R5", "lower half data", {16'h0, rd}, {16'h0, word_m[15:0]});
      chk("R9", "turnaround zero", {30'h0, oe_seen, t}, 32'h2);
      chk("R9", "released after frame", {31'h0, mdio_oe}, 32'h0);
   endtask

   task automatic do_hi_rd(input logic [4:0] p, input logic [4:0] r);
      logic [15:0] rd; logic t;
      int c0 = req_cnt;
      frame(2'b10, p, r | 5'h01, 16'h0, 1'b1, rd, t);
      chk("R6", "odd read makes no request", req_cnt, c0);
      chk("R6", "upper half of kept word", {16'h0, rd}, {16'h0, word_m[31:16]});
   endtask

   task automatic do_ignored(input string rq, input logic [1:0] op, input logic [4:0] p,
                             input logic [4:0] r, input logic [15:0] d, input logic st1);
      logic [15:0] rd; logic t;
      int c0 = req_cnt;
      frame(op, p, r, d, st1, rd, t);
      chk(rq, "ignored frame makes no request", req_cnt, c0);
      chk(rq, "ignored frame never drives", {31'h0, oe_seen}, 32'h0);
   endtask

   function automatic logic [4:0] data_phy();
      return 5'h10 | 5'($urandom_range(0, 7));
   endfunction

   function automatic logic [4:0] foreign_phy();
      logic [4:0] p;
      do p = 5'($urandom_range(0, 31));
      while ((p[4] && !p[3]) || p == 5'h1f);
      return p;
   endfunction

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (6) @(negedge clk);
      // R9 R10 reset state
      chk("R9", "reset oe", {31'h0, mdio_oe}, 32'h0);
      chk("R10", "reset request", {31'h0, rb_req}, 32'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      do_page_rd();                         // R1 reset value 0
      do_page_wr(16'hF1A5);                 // R1
      do_page_rd();
      do_hi_rd(5'h12, 5'h03);               // R6 before any fetch: 0
      do_hi_wr(5'h13, 5'h07, 16'hBEEF);     // R2
      do_lo_wr(5'h13, 5'h06, 16'h1234);     // R3 R4
      do_lo_wr(5'h17, 5'h1e, 16'h5555);     // R11 reuse of upper half
      do_lo_rd(5'h10, 5'h00);               // R5
      do_hi_rd(5'h10, 5'h01);               // R6
      do_ignored("R7", 2'b01, 5'h08, 5'h10, 16'h0077, 1'b1);
      do_ignored("R7", 2'b01, 5'h1f, 5'h11, 16'h0033, 1'b1);
      do_ignored("R7", 2'b10, 5'h1e, 5'h02, 16'h0, 1'b1);
      do_ignored("R8", 2'b00, 5'h11, 5'h04, 16'hAAAA, 1'b1);
      do_ignored("R8", 2'b11, 5'h11, 5'h04, 16'hAAAA, 1'b1);
      do_ignored("R8", 2'b01, 5'h11, 5'h04, 16'hAAAA, 1'b0);
      do_page_rd();                         // R7 page unchanged

      for (int it = 0; it < 50; it++) begin
         int k = $urandom_range(0, 5);
         logic [4:0] p = data_phy();
         logic [4:0] r = 5'($urandom_range(0, 31));
         logic [15:0] d = 16'($urandom);
         case (k)
            0: begin do_page_wr(d); do_page_rd(); end
            1: do_hi_wr(p, r, d);
            2: do_lo_wr(p, r, d);
            3: do_lo_rd(p, r);
            4: do_hi_rd(p, r);
            default: do_ignored("R7", ($urandom_range(0, 1) != 0) ? 2'b10 : 2'b01,
                                foreign_phy(), r, d, 1'b1);
         endcase
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule